// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block sits at the home node of a distributed shared-memory machine. It keeps directory entries for a small, parameterized set of memory blocks. Each entry holds a coherence state and a sharer bit vector with one bit per processor node. The states are Uncached, where no cache holds a copy; Shared, where one or more caches hold a clean copy and memory is current; and Exclusive, where exactly one node owns the block and memory is stale.

Remote nodes send requests, each naming the requesting node and a block address. The controller updates the entry in the cycle it accepts the request. It then issues the messages that the transition calls for, one per cycle, on a single message port. Invalidates come first, in ascending node order. Next comes any fetch or fetch-with-invalidate to the owner. The data reply to the requester comes last.

While messages are still pending, the controller deasserts its ready output and does not accept new requests. The interconnect, the remote caches and the memory data array lie outside the block. Requests are assumed to arrive in order.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read miss (`req_kind`=0) to an Uncached block sends one data reply to the requester and leaves the block Shared with sharers = {requester}.
- R3: A read miss to a Shared block sends one data reply and adds the requester to the sharers; no other message is sent.
- R4: A write miss (`req_kind`=1) to an Uncached or Shared block sends an invalidate to each current sharer other than the requester, in ascending node order. It then sends a data reply. The block becomes Exclusive, owned by the requester.
- R5: A read miss to an Exclusive block owned by another node sends a fetch to the owner and then a data reply. The block becomes Shared with sharers = {owner, requester}.
- R6: A write miss to an Exclusive block owned by another node sends a fetch-and-invalidate to the owner and then a data reply. The block stays Exclusive, owned by the requester.
- R7: A data write-back (`req_kind`=2) from the owner of an Exclusive block sends no message. The block becomes Uncached with no sharers.
- R8: A write-back from a node that does not own the block, or to a block that is not Exclusive, sends no message and leaves the entry unchanged.
- R9: The requester is never sent an invalidate, fetch or fetch-and-invalidate for its own request.
- R10: Messages appear one per cycle. The first appears in the cycle after acceptance, and the data reply is always the last. `req_ready` is 0 in every cycle a message is out and returns to 1 in the cycle after the last one. Requests presented while `req_ready` is 0 are ignored.
- R11: Message kinds on `msg_kind` are 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate. `msg_addr` carries the request's block address for every message of that request.
- R12: Each block's entry evolves independently of the other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 data write-back, 3 no operation |
| req_node | input | $clog2(NODES) | Requesting node |
| req_addr | input | $clog2(NBLK) | Block address |
| req_ready | output | 1 | Controller idle; a valid request is accepted on this edge |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_node | output | $clog2(NODES) | Destination node |
| msg_addr | output | $clog2(NBLK) | Block address of the message |

## Verification
A request is accepted at the rising edge where both `req_valid` and `req_ready` are high. The directory entry changes at that same edge. Message k of the response (counting from 1) is on the port during the k-th cycle after that edge, and `req_ready` rises one cycle after the last message. The bench drives and samples on falling edges: it reads the first message half a cycle after acceptance and each later one a full cycle after the previous, so the count of messages and the return of ready are checked in exact cycles. Entry contents are observed only through the messages that a later request produces.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    DS_UNCACHED = 2'd0,
    DS_SHARED   = 2'd1,
    DS_EXCL     = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_WBACK = 2'd2,
    RQ_NONE  = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    MS_REPLY     = 2'd0,
    MS_INVAL     = 2'd1,
    MS_FETCH     = 2'd2,
    MS_FETCH_INV = 2'd3
  } msg_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NBLK  = 8,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output dstate_e          rd_state,
  output logic [NODES-1:0] rd_sharers,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  dstate_e          wr_state,
  input  logic [NODES-1:0] wr_sharers
);
  dstate_e          st_q [NBLK];
  logic [NODES-1:0] sh_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g] <= DS_UNCACHED;
        sh_q[g] <= '0;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        st_q[g] <= wr_state;
        sh_q[g] <= wr_sharers;
      end
    end
  end

  always_comb begin
    rd_state   = DS_UNCACHED;
    rd_sharers = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (rd_addr == AW'(i)) begin
        rd_state   = st_q[i];
        rd_sharers = sh_q[i];
      end
    end
  end
endmodule

// File: rtl/dir_next.sv
module dir_next
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [1:0]       kind,
  input  logic [NW-1:0]    node,
  input  dstate_e          cur_state,
  input  logic [NODES-1:0] cur_sharers,
  output logic             upd_en,
  output dstate_e          nxt_state,
  output logic [NODES-1:0] nxt_sharers,
  output logic [NODES-1:0] inv_mask,
  output logic             fwd_en,
  output msg_e             fwd_kind,
  output logic [NW-1:0]    fwd_node,
  output logic             reply_en
);
  function automatic logic [NODES-1:0] node_bit(input logic [NW-1:0] n);
    return NODES'(1) << n;
  endfunction

  function automatic logic [NW-1:0] lowest_node(input logic [NODES-1:0] m);
    logic [NW-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (m[i]) r = NW'(i);
    return r;
  endfunction

  logic [NODES-1:0] self_bit;
  logic [NW-1:0]    owner;
  logic             owner_is_self;

  assign self_bit      = node_bit(node);
  assign owner         = lowest_node(cur_sharers);
  assign owner_is_self = (owner == node);

  always_comb begin
    upd_en      = 1'b0;
    nxt_state   = cur_state;
    nxt_sharers = cur_sharers;
    inv_mask    = '0;
    fwd_en      = 1'b0;
    fwd_kind    = MS_FETCH;
    fwd_node    = owner;
    reply_en    = 1'b0;
    case (kind)
      RQ_READ: begin
        upd_en      = 1'b1;
        reply_en    = 1'b1;
        nxt_state   = DS_SHARED;
        nxt_sharers = (cur_state == DS_UNCACHED) ? self_bit : (cur_sharers | self_bit);
        if (cur_state == DS_EXCL && !owner_is_self) begin
          fwd_en   = 1'b1;
          fwd_kind = MS_FETCH;
        end
      end
      RQ_WRITE: begin
        upd_en      = 1'b1;
        reply_en    = 1'b1;
        nxt_state   = DS_EXCL;
        nxt_sharers = self_bit;
        if (cur_state != DS_EXCL) begin
          inv_mask = cur_sharers & ~self_bit;
        end else if (!owner_is_self) begin
          fwd_en   = 1'b1;
          fwd_kind = MS_FETCH_INV;
        end
      end
      RQ_WBACK: begin
        if (cur_state == DS_EXCL && cur_sharers == self_bit) begin
          upd_en      = 1'b1;
          nxt_state   = DS_UNCACHED;
          nxt_sharers = '0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_sequencer.sv
module dir_sequencer
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NBLK  = 8,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] ld_inv,
  input  logic             ld_fwd,
  input  msg_e             ld_fwd_kind,
  input  logic [NW-1:0]    ld_fwd_node,
  input  logic             ld_reply,
  input  logic [NW-1:0]    ld_node,
  input  logic [AW-1:0]    ld_addr,
  output logic             busy,
  output logic [NW-1:0]    cur_node,
  output logic             out_valid,
  output msg_e             out_kind,
  output logic [NW-1:0]    out_node,
  output logic [AW-1:0]    out_addr
);
  function automatic logic [NW-1:0] lowest_node(input logic [NODES-1:0] m);
    logic [NW-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (m[i]) r = NW'(i);
    return r;
  endfunction

  logic [NODES-1:0] inv_q;
  logic             fwd_q, reply_q;
  msg_e             fwd_kind_q;
  logic [NW-1:0]    fwd_node_q, node_q;
  logic [AW-1:0]    addr_q;
  logic [NODES-1:0] inv_clr;
  logic             fwd_take, reply_take;

  always_comb begin
    out_valid  = 1'b0;
    out_kind   = MS_REPLY;
    out_node   = node_q;
    inv_clr    = '0;
    fwd_take   = 1'b0;
    reply_take = 1'b0;
    if (|inv_q) begin
      out_valid = 1'b1;
      out_kind  = MS_INVAL;
      out_node  = lowest_node(inv_q);
      inv_clr   = NODES'(1) << out_node;
    end else if (fwd_q) begin
      out_valid = 1'b1;
      out_kind  = fwd_kind_q;
      out_node  = fwd_node_q;
      fwd_take  = 1'b1;
    end else if (reply_q) begin
      out_valid  = 1'b1;
      reply_take = 1'b1;
    end
  end

  assign busy     = (|inv_q) | fwd_q | reply_q;
  assign out_addr = addr_q;
  assign cur_node = node_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q      <= '0;
      fwd_q      <= 1'b0;
      reply_q    <= 1'b0;
      fwd_kind_q <= MS_FETCH;
      fwd_node_q <= '0;
      node_q     <= '0;
      addr_q     <= '0;
    end else if (load) begin
      inv_q      <= ld_inv;
      fwd_q      <= ld_fwd;
      reply_q    <= ld_reply;
      fwd_kind_q <= ld_fwd_kind;
      fwd_node_q <= ld_fwd_node;
      node_q     <= ld_node;
      addr_q     <= ld_addr;
    end else begin
      inv_q <= inv_q & ~inv_clr;
      if (fwd_take)   fwd_q   <= 1'b0;
      if (reply_take) reply_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NBLK  = 8,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [NW-1:0] req_node,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          msg_valid,
  output logic [1:0]    msg_kind,
  output logic [NW-1:0] msg_node,
  output logic [AW-1:0] msg_addr
);
  dstate_e          rd_state, nxt_state;
  logic [NODES-1:0] rd_sharers, nxt_sharers, inv_mask;
  logic             upd_en, fwd_en, reply_en;
  msg_e             fwd_kind, out_kind;
  logic [NW-1:0]    fwd_node, cur_node;
  logic             busy, accept, dir_write;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign dir_write = accept && upd_en;

  dir_store #(.NODES(NODES), .NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_addr), .rd_state(rd_state), .rd_sharers(rd_sharers),
    .wr_en(dir_write), .wr_addr(req_addr),
    .wr_state(nxt_state), .wr_sharers(nxt_sharers)
  );

  dir_next #(.NODES(NODES)) u_next (
    .kind(req_kind), .node(req_node),
    .cur_state(rd_state), .cur_sharers(rd_sharers),
    .upd_en(upd_en), .nxt_state(nxt_state), .nxt_sharers(nxt_sharers),
    .inv_mask(inv_mask), .fwd_en(fwd_en), .fwd_kind(fwd_kind),
    .fwd_node(fwd_node), .reply_en(reply_en)
  );

  dir_sequencer #(.NODES(NODES), .NBLK(NBLK)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .ld_inv(inv_mask), .ld_fwd(fwd_en), .ld_fwd_kind(fwd_kind),
    .ld_fwd_node(fwd_node), .ld_reply(reply_en),
    .ld_node(req_node), .ld_addr(req_addr),
    .busy(busy), .cur_node(cur_node),
    .out_valid(msg_valid), .out_kind(out_kind),
    .out_node(msg_node), .out_addr(msg_addr)
  );

  assign msg_kind = out_kind;
endmodule

// File: rtl/dir_home_checker.sv
module dir_home_checker
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NBLK  = 8,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic [1:0]       req_kind,
  input logic             req_ready,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [NW-1:0]    msg_node,
  input logic [AW-1:0]    msg_addr,
  input logic [NW-1:0]    cur_node,
  input dstate_e          rd_state,
  input logic [NODES-1:0] rd_sharers
);
  AST_MSG_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_kind == RQ_READ || req_kind == RQ_WRITE) |=> msg_valid); // R10
  AST_NOT_READY_WHILE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready); // R10
  AST_REPLY_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MS_REPLY |=> !msg_valid && req_ready); // R10
  AST_NO_SELF_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind != MS_REPLY |-> msg_node != cur_node); // R9
  AST_REPLY_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MS_REPLY |-> msg_node == cur_node); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && $past(msg_valid) |-> $stable(msg_addr)); // R11
  AST_EXCL_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_state == DS_EXCL |-> $countones(rd_sharers) == 1); // R4
  AST_UNCACHED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_state == DS_UNCACHED |-> rd_sharers == '0); // R7
  AST_SHARED_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_state == DS_SHARED |-> rd_sharers != '0); // R3
endmodule

bind dir_home_ctrl dir_home_checker #(.NODES(NODES), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .req_kind(req_kind),
  .req_ready(req_ready), .msg_valid(msg_valid), .msg_kind(msg_kind),
  .msg_node(msg_node), .msg_addr(msg_addr), .cur_node(cur_node),
  .rd_state(rd_state), .rd_sharers(rd_sharers)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;
  localparam int NODES = 4;
  localparam int NBLK  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic [1:0] req_node = '0;
  logic [2:0] req_addr = '0;
  logic       req_ready, msg_valid;
  logic [1:0] msg_kind, msg_node;
  logic [2:0] msg_addr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .NBLK(NBLK)) i_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_node(req_node), .req_addr(req_addr), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
    .msg_addr(msg_addr)
  );

  // message kinds: 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate
  localparam logic [1:0] RP = 2'd0, IV = 2'd1, FE = 2'd2, FI = 2'd3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue one request and check the message train that follows.
  // ek/en hold up to four expected kinds/nodes, element i at [2i+:2].
  task automatic run(input logic [1:0] k, input int nd, input int ad,
                     input int n_exp, input logic [7:0] ek, input logic [7:0] en,
                     input string tag, input bit stray = 1'b0);
    int got;
    chk(req_ready == 1'b1, {tag, " ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_kind = k; req_node = 2'(nd); req_addr = 3'(ad);
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd3;
    got = 0;
    for (int c = 0; c < 8; c++) begin
      if (!msg_valid) break;
      if (got < 4) begin
        chk(msg_kind == ek[2*got+:2], {tag, " kind"}, int'(msg_kind), int'(ek[2*got+:2]));
        chk(msg_node == en[2*got+:2], {tag, " node"}, int'(msg_node), int'(en[2*got+:2]));
        chk(msg_addr == 3'(ad), {tag, " addr R11"}, int'(msg_addr), ad);
      end
      chk(req_ready == 1'b0, {tag, " ready low while sending R10"}, int'(req_ready), 0);
      got++;
      if (stray && got == 1) begin
        req_valid = 1'b1; req_kind = 2'd1; req_node = 2'd3; req_addr = 3'd7;
      end
      @(negedge clk);
      req_valid = 1'b0; req_kind = 2'd3;
    end
    chk(got == n_exp, {tag, " message count"}, got, n_exp);
    chk(req_ready == 1'b1, {tag, " ready after train R10"}, int'(req_ready), 1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(msg_valid == 1'b0, "R1 reset msg_valid", int'(msg_valid), 0);
    run(2'd0, 1, 3, 1, {6'd0, RP}, {6'd0, 2'd1}, "R1 R2 first read miss");
  endtask

  task automatic t_shared_reads;
    run(2'd0, 2, 3, 1, {6'd0, RP}, {6'd0, 2'd2}, "R3 read shared p2");
    run(2'd0, 0, 3, 1, {6'd0, RP}, {6'd0, 2'd0}, "R3 read shared p0");
  endtask

  task automatic t_write_shared;
    // sharers {0,1,2}; p1 writes: invalidate 0, 2, reply 1
    run(2'd1, 1, 3, 3, {2'd0, RP, IV, IV}, {2'd0, 2'd1, 2'd2, 2'd0}, "R4 R9 write shared");
  endtask

  task automatic t_read_excl;
    run(2'd0, 3, 3, 2, {4'd0, RP, FE}, {4'd0, 2'd3, 2'd1}, "R5 read excl");
    // sharers {1,3}; p0 writes
    run(2'd1, 0, 3, 3, {2'd0, RP, IV, IV}, {2'd0, 2'd0, 2'd3, 2'd1}, "R4 write after R5");
  endtask

  task automatic t_write_excl;
    run(2'd1, 2, 3, 2, {4'd0, RP, FI}, {4'd0, 2'd2, 2'd0}, "R6 write excl");
  endtask

  task automatic t_wback;
    run(2'd2, 1, 3, 0, 8'd0, 8'd0, "R8 write-back non-owner");
    run(2'd0, 0, 3, 2, {4'd0, RP, FE}, {4'd0, 2'd0, 2'd2}, "R8 still owned by p2");
    run(2'd2, 1, 3, 0, 8'd0, 8'd0, "R8 write-back to shared");
    run(2'd1, 3, 3, 3, {2'd0, RP, IV, IV}, {2'd0, 2'd3, 2'd2, 2'd0}, "R8 shared unchanged");
    run(2'd2, 3, 3, 0, 8'd0, 8'd0, "R7 owner write-back");
    run(2'd0, 1, 3, 1, {6'd0, RP}, {6'd0, 2'd1}, "R7 block uncached");
  endtask

  task automatic t_self;
    run(2'd1, 2, 5, 1, {6'd0, RP}, {6'd0, 2'd2}, "R4 write uncached");
    run(2'd1, 2, 5, 1, {6'd0, RP}, {6'd0, 2'd2}, "R9 owner rewrites");
    run(2'd0, 2, 5, 1, {6'd0, RP}, {6'd0, 2'd2}, "R9 owner reads");
    run(2'd1, 2, 5, 1, {6'd0, RP}, {6'd0, 2'd2}, "R9 sole sharer writes");
  endtask

  task automatic t_independent;
    run(2'd0, 3, 0, 1, {6'd0, RP}, {6'd0, 2'd3}, "R12 other block uncached");
    run(2'd1, 0, 3, 2, {4'd0, RP, IV}, {4'd0, 2'd0, 2'd1}, "R12 block3 kept sharers");
  endtask

  task automatic t_busy_ignore;
    run(2'd0, 0, 6, 1, {6'd0, RP}, {6'd0, 2'd0}, "R10 setup a");
    run(2'd0, 1, 6, 1, {6'd0, RP}, {6'd0, 2'd1}, "R10 setup b");
    run(2'd1, 2, 6, 3, {2'd0, RP, IV, IV}, {2'd0, 2'd2, 2'd1, 2'd0}, "R10 busy train", 1'b1);
    // the stray write miss to block 7 must not have been taken
    run(2'd0, 0, 7, 1, {6'd0, RP}, {6'd0, 2'd0}, "R10 stray ignored");
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared_reads();
    t_write_shared();
    t_read_excl();
    t_write_excl();
    t_wback();
    t_self();
    t_independent();
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule